// File: doc/BRIEF.md
# Masked Register Poll Engine

This block waits on a hardware condition held in a 32-bit register that sits behind a slower register bridge. A caller gives it one request: a register address, a bit mask, an expected value and a retry budget. The engine then reads the register through a request/acknowledge read port. After each read it masks the returned word and compares it with the expected value. When they are equal, the poll ends with success. When they differ and retries remain, the engine pauses for one microsecond and reads again. When they differ and no retries remain, the poll ends with a timeout code.

A read that comes back flagged as an error ends the poll at once with its own code. For every outcome, the final word read is shown on the result bus. A one-cycle completion strobe marks the end of each poll. While a poll is running, new requests are refused by holding the ready signal low.

The pause length is derived from a clock-frequency parameter. A budget of N allows at most N+1 reads.

Top module: `reg_poll_engine`

## Requirements
- R1: After reset, `start_ready_o` is 1, `rd_req_o` is 0, `done_o` is 0, `status_o` is 2'b00 and `value_o` is 0.
- R2: A request is taken on a rising edge where `start_valid_i` and `start_ready_o` are both 1. From then until the poll ends, `start_ready_o` is 0. A `start_valid_i` pulse during that time is ignored: it neither restarts the poll nor changes the address being read.
- R3: During an attempt, `rd_req_o` stays at 1 and `rd_addr_o` holds the accepted address until an edge where `rd_ack_i` is 1.
- R4: When an acknowledged read without error satisfies (`rd_data_i` & mask) == expected, `done_o` rises in the next cycle with `status_o` = 2'b01 (success). No further read is made.
- R5: When an acknowledged read mismatches and no retries remain, `done_o` rises in the next cycle with `status_o` = 2'b10 (timeout). A budget of N gives exactly N+1 reads when every read mismatches, and a budget of 0 gives exactly one read.
- R6: When an acknowledged read mismatches and retries remain, the remaining count drops by one. `rd_req_o` is then low for exactly CLK_HZ/1,000,000 cycles (16 at the default), and after that the next read is requested.
- R7: An acknowledge with `rd_err_i` = 1 ends the poll in the next cycle with `status_o` = 2'b11 (bus error), whatever the data or the remaining budget.
- R8: `done_o` is a single-cycle pulse. `value_o` takes the acknowledged `rd_data_i` in the cycle after every acknowledge, for every outcome, and holds it until the next acknowledge. `status_o` holds until the next poll ends.
- R9: A matching read succeeds even when no retries remain.
- R10: `start_ready_o` is already 1 in the cycle `done_o` is high, so a waiting request is taken on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Poll request valid |
| start_ready_o | output | 1 | Engine idle, request can be taken |
| addr_i | input | ADDR_W | Register address to poll |
| mask_i | input | DATA_W | Bits taking part in the compare |
| expect_i | input | DATA_W | Expected value of the masked bits |
| budget_i | input | CNT_W | Number of retries after the first read |
| rd_req_o | output | 1 | Read request to the bridge |
| rd_addr_o | output | ADDR_W | Read address to the bridge |
| rd_ack_i | input | 1 | Read completed, data valid |
| rd_data_i | input | DATA_W | Read data |
| rd_err_i | input | 1 | Read failed, qualified by rd_ack_i |
| done_o | output | 1 | Poll finished, one-cycle pulse |
| status_o | output | 2 | 01 success, 10 timeout, 11 bus error |
| value_o | output | DATA_W | Last word read |

## Verification
Two events can fall in the same cycle: the completion strobe of one poll and the acceptance of the next request. The bench provokes this by keeping a second request valid while the first poll is still running. It then checks that ready rises together with `done_o` and that the new read follows directly. Acknowledges also land exactly on the last retry while carrying a matching word, which tests the order between the match and the exhausted budget. A behavioural reference model predicts ready, request, address, strobe, status and value every cycle, while a scripted responder varies the acknowledge latency.

// File: rtl/reg_poll_pkg.sv
package reg_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_GAP  = 2'd2
  } poll_state_e;

  localparam logic [1:0] STAT_NONE    = 2'b00;
  localparam logic [1:0] STAT_OK      = 2'b01;
  localparam logic [1:0] STAT_TIMEOUT = 2'b10;
  localparam logic [1:0] STAT_BUSERR  = 2'b11;
endpackage

// File: rtl/reg_poll_match.sv
module reg_poll_match #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] expect_i,
  output logic              hit_o
);
  assign hit_o = ((data_i & mask_i) == expect_i);
endmodule

// File: rtl/reg_poll_budget.sv
module reg_poll_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (load_i) left_q <= value_i;
    else if (dec_i)  left_q <= left_q - 1'b1;
  end

  assign zero_o = (left_q == '0);
endmodule

// File: rtl/reg_poll_gap_timer.sv
module reg_poll_gap_timer #(
  parameter int GAP_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int GW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= GW'(GAP_CYCLES - 1);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/reg_poll_engine.sv
module reg_poll_engine
  import reg_poll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int CLK_HZ = 16_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] expect_i,
  input  logic [CNT_W-1:0]  budget_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_err_i,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [DATA_W-1:0] value_o
);
  localparam int GAP_RAW    = CLK_HZ / 1_000_000;
  localparam int GAP_CYCLES = (GAP_RAW < 1) ? 1 : GAP_RAW;

  poll_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] expect_q;
  logic [DATA_W-1:0] value_q;
  logic [1:0]        status_q;
  logic              done_q;

  logic accept, hit, budget_zero, gap_expired, retry;

  assign accept = (state_q == ST_IDLE) && start_valid_i;
  assign retry  = (state_q == ST_READ) && rd_ack_i && !rd_err_i && !hit && !budget_zero;

  reg_poll_match #(.DATA_W(DATA_W)) u_match (
    .data_i   (rd_data_i),
    .mask_i   (mask_q),
    .expect_i (expect_q),
    .hit_o    (hit)
  );

  reg_poll_budget #(.CNT_W(CNT_W)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .value_i (budget_i),
    .dec_i   (retry),
    .zero_o  (budget_zero)
  );

  reg_poll_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (retry),
    .run_i     (state_q == ST_GAP),
    .expired_o (gap_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      mask_q   <= '0;
      expect_q <= '0;
      value_q  <= '0;
      status_q <= STAT_NONE;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_valid_i) begin
            addr_q   <= addr_i;
            mask_q   <= mask_i;
            expect_q <= expect_i;
            state_q  <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_ack_i) begin
            value_q <= rd_data_i;
            if (rd_err_i) begin
              status_q <= STAT_BUSERR;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (hit) begin
              status_q <= STAT_OK;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (budget_zero) begin
              status_q <= STAT_TIMEOUT;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_expired) state_q <= ST_READ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_ready_o = (state_q == ST_IDLE);
  assign rd_req_o      = (state_q == ST_READ);
  assign rd_addr_o     = addr_q;
  assign done_o        = done_q;
  assign status_o      = status_q;
  assign value_o       = value_q;
endmodule

// File: rtl/reg_poll_engine_chk.sv
module reg_poll_engine_chk
  import reg_poll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_ready_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              rd_err_i,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic [DATA_W-1:0] value_o,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] expect_q
);
  p_busy_not_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !start_ready_o);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

  p_match_ok_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i && !rd_err_i && ((rd_data_i & mask_q) == expect_q)
      |=> done_o && status_o == STAT_OK);

  p_err_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i && rd_err_i |=> done_o && status_o == STAT_BUSERR && !rd_req_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_value_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> value_o == $past(rd_data_i));

  p_done_coded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> status_o != STAT_NONE);

  p_ready_at_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> start_ready_o);
endmodule

bind reg_poll_engine reg_poll_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_ready_o (start_ready_o),
  .rd_req_o      (rd_req_o),
  .rd_addr_o     (rd_addr_o),
  .rd_ack_i      (rd_ack_i),
  .rd_data_i     (rd_data_i),
  .rd_err_i      (rd_err_i),
  .done_o        (done_o),
  .status_o      (status_o),
  .value_o       (value_o),
  .mask_q        (mask_q),
  .expect_q      (expect_q)
);

// File: tb/reg_poll_engine_test.sv
module reg_poll_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int HZ = 16_000_000;
  localparam int GAP = HZ / 1_000_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] mask = '0;
  logic [DW-1:0] expv = '0;
  logic [CW-1:0] budget = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          rd_err = 1'b0;
  logic          done;
  logic [1:0]    status;
  logic [DW-1:0] value;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_poll_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .CLK_HZ(HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .start_valid_i(start_valid), .start_ready_o(start_ready),
    .addr_i(addr), .mask_i(mask), .expect_i(expv), .budget_i(budget),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack),
    .rd_data_i(rd_data), .rd_err_i(rd_err),
    .done_o(done), .status_o(status), .value_o(value)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int attempts = 0;
  int wait_cnt = 0;
  bit accepted_on_done = 0;

  int          q_lat[$];
  logic [31:0] q_data[$];
  bit          q_err[$];

  // reference model state
  int          m_phase = 0;  // 0 idle, 1 reading, 2 pausing
  int          m_rem = 0;
  int          m_gap = 0;
  logic [15:0] m_addr = '0;
  logic [31:0] m_mask = '0, m_exp = '0, m_value = '0;
  logic [1:0]  m_status = 2'b00;
  bit          m_done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  function automatic string stat_tag(logic [1:0] s);
    case (s)
      2'b01: return "R4";
      2'b10: return "R5";
      2'b11: return "R7";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_rem <= 0; m_gap <= 0; m_done <= 0;
      m_status <= 2'b00; m_value <= '0;
    end else begin
      m_done <= 0;
      if (m_phase == 0) begin
        if (start_valid) begin
          m_addr <= addr; m_mask <= mask; m_exp <= expv;
          m_rem <= int'(budget); m_phase <= 1;
        end
      end else if (m_phase == 1) begin
        if (rd_ack) begin
          m_value <= rd_data;
          if (rd_err) begin
            m_status <= 2'b11; m_done <= 1; m_phase <= 0;
          end else if ((rd_data & m_mask) == m_exp) begin
            m_status <= 2'b01; m_done <= 1; m_phase <= 0;
          end else if (m_rem == 0) begin
            m_status <= 2'b10; m_done <= 1; m_phase <= 0;
          end else begin
            m_rem <= m_rem - 1; m_gap <= GAP; m_phase <= 2;
          end
        end
      end else begin
        if (m_gap == 1) m_phase <= 1;
        else m_gap <= m_gap - 1;
      end
    end
  end

  // compare, then drive the scripted responder
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R2", 32'(start_ready), 32'(m_phase == 0));
      check("R3", 32'(rd_req), 32'(m_phase == 1));
      if (m_phase == 1) check("R3", 32'(rd_addr), 32'(m_addr));
      check("R8", 32'(done), 32'(m_done));
      check(stat_tag(m_status), 32'(status), 32'(m_status));
      check("R8", value, m_value);
    end
    rd_ack = 0; rd_err = 0;
    if (rst_n && rd_req) begin
      int lat;
      lat = (q_lat.size() > 0) ? q_lat[0] : 0;
      if (wait_cnt >= lat) begin
        rd_ack = 1;
        if (q_lat.size() > 0) begin
          rd_data = q_data.pop_front(); rd_err = q_err.pop_front(); void'(q_lat.pop_front());
        end else rd_data = '0;
        attempts++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic push(int lat, logic [31:0] d, bit e);
    q_lat.push_back(lat); q_data.push_back(d); q_err.push_back(e);
  endtask

  task automatic start_poll(logic [15:0] a, logic [31:0] m, logic [31:0] x, int b);
    bit took;
    addr = a; mask = m; expv = x; budget = CW'(b); start_valid = 1;
    while (1) begin
      took = start_ready;
      accepted_on_done = took && done;
      @(negedge clk);
      if (took) break;
    end
    start_valid = 0;
    attempts = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'(start_ready), 32'd1);
    check("R1", 32'(rd_req), 32'd0);
    check("R1", 32'(done), 32'd0);
    check("R1", 32'(status), 32'd0);
    check("R1", value, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R4: match on second read after one pause (R6)
    push(2, 32'h1234_5601, 0); push(0, 32'hABCD_0057, 0);
    start_poll(16'h0040, 32'h0000_00F0, 32'h0000_0050, 4);
    wait_done();
    check("R4", 32'(attempts), 32'd2);

    // R5: budget 2, all mismatch -> 3 reads, timeout
    push(1, 32'h0, 0); push(0, 32'h1, 0); push(3, 32'h2, 0);
    start_poll(16'h1230, 32'hFFFF_0000, 32'hDEAD_0000, 2);
    wait_done();
    check("R5", 32'(attempts), 32'd3);
    check("R5", 32'(status), 32'h2);

    // R5: budget 0 mismatch -> single read
    push(0, 32'h0000_0F00, 0);
    start_poll(16'h0008, 32'h0000_0F00, 32'h0, 0);
    wait_done();
    check("R5", 32'(attempts), 32'd1);
    check("R8", value, 32'h0000_0F00);

    // R9: budget 0 but matching read succeeds
    push(2, 32'h8000_0001, 0);
    start_poll(16'h000C, 32'h8000_0000, 32'h8000_0000, 0);
    wait_done();
    check("R9", 32'(status), 32'h1);
    check("R9", 32'(attempts), 32'd1);

    // R7: bus error on second read despite budget left
    push(0, 32'h0, 0); push(1, 32'hFFFF_FFFF, 1);
    start_poll(16'h0100, 32'h1, 32'h1, 5);
    wait_done();
    check("R7", 32'(attempts), 32'd2);
    check("R7", 32'(status), 32'h3);

    // R2: request pulsed while busy is ignored
    push(3, 32'h0, 0); push(3, 32'h10, 0);
    start_poll(16'h0200, 32'h10, 32'h10, 1);
    addr = 16'hBEEF; mask = 32'h0; expv = 32'h0; start_valid = 1;
    repeat (2) @(negedge clk);
    start_valid = 0;
    check("R2", 32'(rd_addr), 32'h0200);
    wait_done();
    check("R2", 32'(attempts), 32'd2);
    check("R2", value, 32'h10);

    // R10: second request waits and is taken in the done cycle
    push(4, 32'h5, 0); push(0, 32'h7, 0);
    start_poll(16'h0300, 32'hF, 32'h5, 0);
    start_poll(16'h0304, 32'hF, 32'h7, 0);
    check("R10", 32'(accepted_on_done), 32'd1);
    check("R10", 32'(rd_req), 32'd1);
    wait_done();
    check("R10", 32'(status), 32'h1);
    check("R10", value, 32'h7);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule